// File: doc/BRIEF.md
# Symmetric Divide-by-158 Shift-Register Clock Divider

This block divides its clock by 158 and delivers a square wave with equal high and low phases. It has no binary counter. A count of 79 comes from two small feedback shift registers in cascade. A 3-bit prescaler register normally cycles through five states. A 4-bit register advances once for each prescaler wrap and walks a 16-state sequence. When the 4-bit register sits in its final state, the prescaler's wrap is redirected so that it skips one state. That one pass therefore lasts four clocks instead of five, which gives 16 × 5 − 1 = 79 clocks between carries. A toggle flip-flop that flips on every carry turns the modulo-79 rate into a 50 % duty output with a period of 158 clocks.

Each register's next input bit is the inverted top bit, corrected at a few chosen states. These corrections shorten the prescaler loop, tie its stray two-state loop back into the main path, and merge the two loops of the 4-bit register into one. No power-up state can therefore trap the divider. The carry is brought out as a one-cycle strobe for observation, for example by the phase detector of a surrounding loop.

Top module: `div158_sr`

## Requirements
- R1: A clock edge with `rst` high puts the divider in its start state: `div_o` and `carry_o` read 0 in the following cycle.
- R2: Once running, `div_o` has a period of exactly 158 clocks, measured from one rising transition to the next.
- R3: Every high phase and every low phase of `div_o` lasts exactly 79 consecutive cycles.
- R4: `carry_o` is high for a single cycle at a time, and consecutive carry pulses are exactly 79 clocks apart.
- R5: Counting the first edge after reset is released as edge 1, `carry_o` is first high after edge 79, and `div_o` first goes high after edge 80.
- R6: `div_o` changes on the edge that follows a cycle with `carry_o` high, and only on such an edge.
- R7: Asserting `rst` while the divider is running, including during a high output phase, clears `div_o` and `carry_o` at once. After release, the timing of R5 repeats exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| div_o | output | 1 | Symmetric output at the clock rate divided by 158 |
| carry_o | output | 1 | One-cycle strobe each time the modulo-79 count wraps |

## Verification
The divider has no data inputs, so the main pattern is one long free run from reset. It spans about ten output periods and therefore passes through the shortened prescaler pass many times. In that run every carry spacing, every phase length and every full period is measured, which separates an error in the prescaler loop from one in the 4-bit sequence or in the terminal-state decode. A second run is reset partway through a high phase, which shows that a restart from the middle of the sequence reproduces the exact timing seen after power-up. Reset is also applied on its own, to show that both outputs return to zero.

// File: rtl/div158_pkg.sv
package div158_pkg;

   // Next serial input bit of a twisted-ring register: the inverted last stage,
   // optionally complemented by a correction chosen for the current state.
   function automatic logic ring_din(input logic last_stage, input logic correct);
      return (~last_stage) ^ correct;
   endfunction

   // Nominal prescaler length (clocks per pass without modulation)
   localparam int unsigned PRE_LEN = 5;

endpackage

// File: rtl/fsr_stage.sv
module fsr_stage #(
   parameter int unsigned W           = 3,
   parameter logic [2**W-1:0] FLIP_MASK = '0,
   parameter int unsigned TERM_STATE  = 0,
   parameter int unsigned MOD_STATE   = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic mod_i,
   output logic term_o
);
   import div158_pkg::*;

   localparam logic [W-1:0] TERM_V = W'(TERM_STATE);
   localparam logic [W-1:0] MOD_V  = W'(MOD_STATE);

   generate
      if (W < 2) begin : g_bad_width
         $error("fsr_stage: W must be at least 2");
      end
      if (TERM_STATE >= 2**W) begin : g_bad_term
         $error("fsr_stage: TERM_STATE out of range");
      end
      if (MOD_STATE >= 2**W) begin : g_bad_mod
         $error("fsr_stage: MOD_STATE out of range");
      end
   endgenerate

   logic [W-1:0] st_q;
   logic         fix;
   logic         din;

   always_comb begin
      fix = FLIP_MASK[st_q] ^ (mod_i && (st_q == MOD_V));
      din = ring_din(st_q[W-1], fix);
   end

   always_ff @(posedge clk) begin
      if (rst)     st_q <= '0;
      else if (en) st_q <= {st_q[W-2:0], din};
   end

   assign term_o = (st_q == TERM_V);

   // R2: an enabled shift never leaves the register where it was (no stuck state)
   p_no_stall_r2: assert property (@(posedge clk) disable iff (rst)
      en |=> (st_q != $past(st_q)));

endmodule

// File: rtl/toggle_ff.sv
module toggle_ff (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= 1'b0;
      else if (tick) q <= ~q;
   end

   // R6: a tick always flips the output on the next edge
   p_flip_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
      tick |=> (q != $past(q)));
   // R6: without a tick the output holds
   p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(q));
endmodule

// File: rtl/div158_sr.sv
module div158_sr #(
   parameter int unsigned PRE_W       = 3,
   parameter logic [2**PRE_W-1:0] PRE_FLIP = 8'b0000_1100,
   parameter int unsigned PRE_WRAP    = 4,
   parameter int unsigned SEQ_W       = 4,
   parameter logic [2**SEQ_W-1:0] SEQ_FLIP = 16'h0202,
   parameter int unsigned SEQ_LAST    = 8,
   parameter int unsigned HALF_PERIOD = 79
) (
   input  logic clk,
   input  logic rst,
   output logic div_o,
   output logic carry_o
);
   import div158_pkg::*;

   localparam int unsigned SEQ_LEN = 2**SEQ_W;
   localparam int unsigned GAP_W   = $clog2(HALF_PERIOD + 1) + 1;

   generate
      if (HALF_PERIOD != SEQ_LEN * PRE_LEN - 1) begin : g_bad_half
         $error("div158_sr: HALF_PERIOD must equal SEQ_LEN*PRE_LEN-1");
      end
   endgenerate

   logic pre_wrap;
   logic seq_last;
   logic carry;

   // Prescaler: wraps every 5 clocks, every 4 when the sequencer is at its last state
   fsr_stage #(
      .W(PRE_W), .FLIP_MASK(PRE_FLIP),
      .TERM_STATE(PRE_WRAP), .MOD_STATE(PRE_WRAP)
   ) u_pre (
      .clk(clk), .rst(rst), .en(1'b1), .mod_i(seq_last), .term_o(pre_wrap)
   );

   // Sequencer: 16-state merged ring stepped by the prescaler wrap
   fsr_stage #(
      .W(SEQ_W), .FLIP_MASK(SEQ_FLIP),
      .TERM_STATE(SEQ_LAST), .MOD_STATE(0)
   ) u_seq (
      .clk(clk), .rst(rst), .en(pre_wrap), .mod_i(1'b0), .term_o(seq_last)
   );

   assign carry   = pre_wrap & seq_last;
   assign carry_o = carry;

   toggle_ff u_tog (.clk(clk), .rst(rst), .tick(carry), .q(div_o));

   // Clocks since reset or since the last carry, for the spacing checks
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (rst)        gap_q <= '0;
      else if (carry) gap_q <= GAP_W'(1);
      else            gap_q <= gap_q + GAP_W'(1);
   end

   // R1: the cycle after a reset edge shows both outputs low
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!div_o && !carry_o));
   // R4: each carry arrives exactly HALF_PERIOD clocks after the previous one (or after reset)
   p_carry_gap_r4: assert property (@(posedge clk) disable iff (rst)
      carry_o |-> (gap_q == GAP_W'(HALF_PERIOD)));
   // R4: the gap never runs past the period without a carry
   p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
      gap_q <= GAP_W'(HALF_PERIOD));
   // R4: carry is a single-cycle pulse
   p_carry_single_r4: assert property (@(posedge clk) disable iff (rst)
      carry_o |=> !carry_o);

endmodule

// File: tb/div158_sr_tb.sv
module div158_sr_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int HALF = 79;
   localparam int FULL = 2 * HALF;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic div_o;
   logic carry_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   div158_sr u_dut (.clk(clk), .rst(rst), .div_o(div_o), .carry_o(carry_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Hold reset over a few edges, then release at a falling edge (state index 0)
   task automatic do_reset(input string req);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(div_o == 1'b0, {req, " div_o low in reset"}, int'(div_o), 0);
      chk(carry_o == 1'b0, {req, " carry_o low in reset"}, int'(carry_o), 0);
      rst = 1'b0;
      chk(div_o == 1'b0, {req, " div_o low at release"}, int'(div_o), 0);
      chk(carry_o == 1'b0, {req, " carry_o low at release"}, int'(carry_o), 0);
   endtask

   // Run ncyc edges from the reset start state and measure all timing
   task automatic run_window(input int ncyc, input string first_req);
      int last_carry = -1;
      int last_tog   = -1;
      int last_rise  = -1;
      int ncarry     = 0;
      int exp_carry;
      logic prev_o = 1'b0;
      logic prev_c = 1'b0;
      for (int n = 1; n <= ncyc; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (carry_o) begin
            ncarry++;
            chk(!prev_c, "R4 carry width one cycle", int'(prev_c), 0);
            if (last_carry < 0) chk(n == HALF, {first_req, " first carry edge"}, n, HALF);
            else                chk(n - last_carry == HALF, "R4 carry spacing", n - last_carry, HALF);
            last_carry = n;
         end
         if (div_o != prev_o) begin
            chk(prev_c, "R6 output change without carry", int'(prev_c), 1);
            if (last_tog < 0) begin
               chk(n == HALF + 1, {first_req, " first output rise edge"}, n, HALF + 1);
               chk(div_o == 1'b1, {first_req, " first change is a rise"}, int'(div_o), 1);
            end else begin
               chk(n - last_tog == HALF, "R3 phase length", n - last_tog, HALF);
            end
            last_tog = n;
            if (div_o) begin
               if (last_rise >= 0) chk(n - last_rise == FULL, "R2 output period", n - last_rise, FULL);
               last_rise = n;
            end
         end else if (prev_c) begin
            chk(1'b0, "R6 no change after carry", int'(div_o), int'(!prev_o));
         end
         prev_o = div_o;
         prev_c = carry_o;
      end
      exp_carry = (ncyc >= HALF) ? ((ncyc - HALF) / HALF + 1) : 0;
      chk(ncarry == exp_carry, "R4 carry count in window", ncarry, exp_carry);
   endtask

   initial begin
      do_reset("R1");
      run_window(1600, "R5");
      do_reset("R1");
      run_window(900, "R5");
      // 11 toggles by edge 900 leave the output in a high phase
      chk(div_o == 1'b1, "R7 output high before mid-run reset", int'(div_o), 1);
      do_reset("R7");
      run_window(400, "R7");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule